// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Aligner

This block sits between a 32-bit register file and a 32-bit big-endian data bus. On the load side it takes the raw word returned by the bus, the two low address bits and the access size, and produces the value to write into the destination register. Byte loads select one lane and zero-extend it. Word loads at a non-aligned offset are rotated into a defined position instead of faulting. The load result is registered and leaves the block one cycle after its data-valid strobe.

On the store side the block takes the source register value, the access size and the low address bits, and produces the bus word and the per-lane write enables. It works without a clock. Byte stores copy the low byte onto every lane and enable one lane. Word stores pass the register through unchanged and enable all lanes. When the source register is the program counter, the stored value is the current instruction address plus 12.

A separate combinational flag reports addressing encodings that must not be issued: write-back onto a program-counter base, the program counter used as a register offset, and post-indexing where the base and offset registers are the same. The big-endian lane numbering puts the byte at address offset 0 in bus bits 31:24.

Top module: `be_lane_aligner`

## Requirements
- R1: A byte load (ld_is_byte_i=1) takes its byte from bus bits 31:24, 23:16, 15:8 or 7:0 for address offsets 0, 1, 2 and 3.
- R2: The byte from a byte load appears in ld_result_o bits 7:0, and bits 31:8 are zero.
- R3: A word load (ld_is_byte_i=0) at offset 0 returns the bus word unchanged. At offset 2 it returns the bus word rotated by 16 bits, so the addressed byte is in bits 31:24.
- R4: A word load at offset 1 or 3 returns the bus word rotated right by 8 or 24 bits, so the addressed byte is in bits 15:8.
- R5: ld_valid_o is high exactly one cycle after ld_valid_i. ld_result_o updates only in that cycle and otherwise holds its value.
- R6: A byte store (st_is_byte_i=1) drives the low 8 bits of the store value onto all four lanes of st_bus_o.
- R7: A word store drives the store value onto st_bus_o unchanged, whatever st_offset_i is. Register bit 31 drives bus bit 31.
- R8: When st_src_is_pc_i=1, the store value is instr_addr_i + 12, wrapping modulo 2^32. Otherwise it is st_data_i.
- R9: st_lane_en_o (bit n enables bus bits 8n+7:8n) is one-hot for byte stores: bit 3 for offset 0 down to bit 0 for offset 3. It is 4'b1111 for word stores.
- R10: illegal_o is 1 in three cases, and 0 otherwise. The register number 15 denotes the program counter.
  - writeback_i=1 with base_reg_i=15.
  - offset_is_reg_i=1 with offset_reg_i=15.
  - post_index_i=1 with offset_is_reg_i=1 and base_reg_i equal to offset_reg_i.
- R11: While rst_n is low at a clock edge, ld_valid_o and ld_result_o are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid_i | input | 1 | Load bus data valid this cycle |
| ld_word_i | input | 32 | Raw word from the big-endian bus |
| ld_offset_i | input | 2 | Low address bits of the load |
| ld_is_byte_i | input | 1 | 1 = byte load, 0 = word load |
| ld_valid_o | output | 1 | Load result valid |
| ld_result_o | output | 32 | Aligned value for the destination register |
| st_data_i | input | 32 | Source register value |
| st_is_byte_i | input | 1 | 1 = byte store, 0 = word store |
| st_offset_i | input | 2 | Low address bits of the store |
| st_src_is_pc_i | input | 1 | Source register is the program counter |
| instr_addr_i | input | 32 | Address of the current instruction |
| st_bus_o | output | 32 | Word driven onto the bus |
| st_lane_en_o | output | 4 | Per-lane write enables |
| base_reg_i | input | 4 | Base register number |
| offset_reg_i | input | 4 | Offset register number |
| offset_is_reg_i | input | 1 | Offset comes from a register |
| writeback_i | input | 1 | Base write-back requested |
| post_index_i | input | 1 | Post-indexed addressing |
| illegal_o | output | 1 | Illegal addressing encoding |

## Verification
The hardest case to reach is the held load result. It only shows when a non-valid cycle carries new bus data and a new offset, so the bench drives a changed word with the strobe low and confirms that the registered output does not move. The program-counter store is exercised at an instruction address near the top of the address space, so that the plus-12 wraps through zero. It is also exercised as a byte store, which shows that the replicated byte comes from the adjusted address and not from the register input. For the illegal flag, the bench sets up near-miss encodings beside each true case, for example a program-counter offset number with a non-register offset, and checks that they stay clear.

// File: rtl/be_align_pkg.sv
// Package: shared types and constants for the big-endian lane aligner.
// Assumes byte-addressed lanes with lane 0 holding the least significant byte.
package be_align_pkg;
    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } acc_size_e;

    // Distance from the current instruction address to the stored PC value.
    localparam int unsigned PC_STORE_ADJ = 12;
endpackage

// File: rtl/be_load_align.sv
// Module: be_load_align
// Combinational load path. It picks a byte lane in big-endian order, or rotates
// the whole word right by one lane width per address-offset step.
// Assumes LANES is a power of two, so the lane index for offset k is ~k.
module be_load_align #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  be_align_pkg::acc_size_e size_i,
    input  logic [OFF_W-1:0]        offset_i,
    input  logic [DATA_W-1:0]       word_i,
    output logic [DATA_W-1:0]       value_o
);
    import be_align_pkg::*;

    logic [BYTE_W-1:0] lane_q [LANES];
    logic [OFF_W-1:0]  lane_idx;
    logic [DATA_W-1:0] rotated;

    // Split the bus word into lanes, lane n covering bits 8n+7:8n.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_q[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // Big-endian lane number: offset 0 maps to the top lane.
    assign lane_idx = ~offset_i;

    // Rotate right by one lane per offset step.
    always_comb begin
        int sh;
        sh = int'(offset_i) * BYTE_W;
        rotated = (word_i >> sh) | (word_i << (DATA_W - sh));
    end

    // Pick the zero-extended byte or the rotated word.
    always_comb begin
        value_o = '0;
        if (size_i == SZ_BYTE) value_o[BYTE_W-1:0] = lane_q[lane_idx];
        else                   value_o = rotated;
    end

    assert_byte_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE) |-> (value_o[DATA_W-1:BYTE_W] == '0));
    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_WORD && offset_i == '0) |-> (value_o == word_i));
    assert_byte_top_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE && offset_i == '0) |->
        (value_o[BYTE_W-1:0] == word_i[DATA_W-1 -: BYTE_W]));
endmodule

// File: rtl/be_store_align.sv
// Module: be_store_align
// Combinational store path. It chooses the PC-adjusted or the register value,
// copies the low byte across all lanes for byte stores, and makes lane enables.
// Assumes LANES is a power of two; the PC adjustment wraps at DATA_W bits.
module be_store_align #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  be_align_pkg::acc_size_e size_i,
    input  logic [OFF_W-1:0]        offset_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic                    src_is_pc_i,
    input  logic [DATA_W-1:0]       pc_i,
    output logic [DATA_W-1:0]       bus_o,
    output logic [LANES-1:0]        lane_en_o
);
    import be_align_pkg::*;

    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] byte_rep;

    // Source value: the register, or the instruction address plus the PC adjustment.
    assign src_val = src_is_pc_i ? (pc_i + DATA_W'(PC_STORE_ADJ)) : data_i;

    // Copy the low byte of the source onto every lane.
    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign byte_rep[g*BYTE_W +: BYTE_W] = src_val[BYTE_W-1:0];
    end

    // Bus word and enables for the two access sizes.
    always_comb begin
        if (size_i == SZ_BYTE) begin
            bus_o     = byte_rep;
            lane_en_o = LANES'(1) << (~offset_i);
        end else begin
            bus_o     = src_val;
            lane_en_o = '1;
        end
    end

    assert_lane_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE) |-> ($countones(lane_en_o) == 1));
    assert_lane_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE && offset_i == '0) |-> lane_en_o[LANES-1]);
    assert_byte_replicated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE) |-> (bus_o[DATA_W-1 -: BYTE_W] == bus_o[BYTE_W-1:0]));
    assert_word_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_WORD && !src_is_pc_i) |-> (bus_o == data_i));
endmodule

// File: rtl/be_addr_check.sv
// Module: be_addr_check
// Flags addressing encodings that must not be issued. It is purely combinational.
// Assumes register numbers are REG_W bits wide and PC_REG is the program counter.
module be_addr_check #(
    parameter int REG_W  = 4,
    parameter int PC_REG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] base_reg_i,
    input  logic [REG_W-1:0] offset_reg_i,
    input  logic             offset_is_reg_i,
    input  logic             writeback_i,
    input  logic             post_index_i,
    output logic             illegal_o
);
    localparam logic [REG_W-1:0] PC_NUM = REG_W'(PC_REG);

    logic wb_on_pc;
    logic pc_offset;
    logic same_post;

    // Evaluate each forbidden combination on its own.
    always_comb begin
        wb_on_pc  = writeback_i && (base_reg_i == PC_NUM);
        pc_offset = offset_is_reg_i && (offset_reg_i == PC_NUM);
        same_post = post_index_i && offset_is_reg_i && (base_reg_i == offset_reg_i);
        illegal_o = wb_on_pc | pc_offset | same_post;
    end

    assert_pc_wb_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (writeback_i && base_reg_i == PC_NUM) |-> illegal_o);
    assert_clean_encoding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!writeback_i && !offset_is_reg_i) |-> !illegal_o);
endmodule

// File: rtl/be_lane_aligner.sv
// Module: be_lane_aligner (top)
// Big-endian load/store lane aligner. The load result is registered one cycle
// after ld_valid_i. The store bus, lane enables and illegal flag are combinational.
// Assumes a synchronous active-low reset.
module be_lane_aligner #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int REG_W  = 4,
    parameter int PC_REG = 15,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid_i,
    input  logic [DATA_W-1:0] ld_word_i,
    input  logic [OFF_W-1:0]  ld_offset_i,
    input  logic              ld_is_byte_i,
    output logic              ld_valid_o,
    output logic [DATA_W-1:0] ld_result_o,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              st_is_byte_i,
    input  logic [OFF_W-1:0]  st_offset_i,
    input  logic              st_src_is_pc_i,
    input  logic [DATA_W-1:0] instr_addr_i,
    output logic [DATA_W-1:0] st_bus_o,
    output logic [LANES-1:0]  st_lane_en_o,
    input  logic [REG_W-1:0]  base_reg_i,
    input  logic [REG_W-1:0]  offset_reg_i,
    input  logic              offset_is_reg_i,
    input  logic              writeback_i,
    input  logic              post_index_i,
    output logic              illegal_o
);
    import be_align_pkg::*;

    logic [DATA_W-1:0] ld_aligned;

    be_load_align #(.LANES(LANES), .BYTE_W(BYTE_W)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .size_i   (acc_size_e'(ld_is_byte_i)),
        .offset_i (ld_offset_i),
        .word_i   (ld_word_i),
        .value_o  (ld_aligned)
    );

    be_store_align #(.LANES(LANES), .BYTE_W(BYTE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .size_i      (acc_size_e'(st_is_byte_i)),
        .offset_i    (st_offset_i),
        .data_i      (st_data_i),
        .src_is_pc_i (st_src_is_pc_i),
        .pc_i        (instr_addr_i),
        .bus_o       (st_bus_o),
        .lane_en_o   (st_lane_en_o)
    );

    be_addr_check #(.REG_W(REG_W), .PC_REG(PC_REG)) u_check (
        .clk             (clk),
        .rst_n           (rst_n),
        .base_reg_i      (base_reg_i),
        .offset_reg_i    (offset_reg_i),
        .offset_is_reg_i (offset_is_reg_i),
        .writeback_i     (writeback_i),
        .post_index_i    (post_index_i),
        .illegal_o       (illegal_o)
    );

    // Register the aligned load value and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid_o  <= 1'b0;
            ld_result_o <= '0;
        end else begin
            ld_valid_o <= ld_valid_i;
            if (ld_valid_i) ld_result_o <= ld_aligned;
        end
    end

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_i |=> ld_valid_o);
    assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> !ld_valid_o);
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> $stable(ld_result_o));
endmodule

// File: tb/sim_be_lane_aligner.sv
module sim_be_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid_i = 1'b0;
    logic [31:0] ld_word_i = '0;
    logic [1:0]  ld_offset_i = '0;
    logic        ld_is_byte_i = 1'b0;
    logic        ld_valid_o;
    logic [31:0] ld_result_o;
    logic [31:0] st_data_i = '0;
    logic        st_is_byte_i = 1'b0;
    logic [1:0]  st_offset_i = '0;
    logic        st_src_is_pc_i = 1'b0;
    logic [31:0] instr_addr_i = '0;
    logic [31:0] st_bus_o;
    logic [3:0]  st_lane_en_o;
    logic [3:0]  base_reg_i = '0;
    logic [3:0]  offset_reg_i = '0;
    logic        offset_is_reg_i = 1'b0;
    logic        writeback_i = 1'b0;
    logic        post_index_i = 1'b0;
    logic        illegal_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    be_lane_aligner u0 (.*);

    // Load vectors: {is_byte, offset, bus word, expected result}.
    localparam int NV = 10;
    localparam logic [66:0] LD_VEC [NV] = '{
        {1'b1, 2'd0, 32'hA1B2C3D4, 32'h000000A1},
        {1'b1, 2'd1, 32'hA1B2C3D4, 32'h000000B2},
        {1'b1, 2'd2, 32'hA1B2C3D4, 32'h000000C3},
        {1'b1, 2'd3, 32'hA1B2C3D4, 32'h000000D4},
        {1'b1, 2'd0, 32'h80FF017E, 32'h00000080},
        {1'b1, 2'd3, 32'h80FF017E, 32'h0000007E},
        {1'b0, 2'd0, 32'hA1B2C3D4, 32'hA1B2C3D4},
        {1'b0, 2'd2, 32'hA1B2C3D4, 32'hC3D4A1B2},
        {1'b0, 2'd1, 32'hA1B2C3D4, 32'hD4A1B2C3},
        {1'b0, 2'd3, 32'hA1B2C3D4, 32'hB2C3D4A1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] d, input logic byt, input logic [1:0] off,
                            input logic pc, input logic [31:0] ia);
        @(negedge clk);
        st_data_i = d; st_is_byte_i = byt; st_offset_i = off;
        st_src_is_pc_i = pc; instr_addr_i = ia;
        #1;
    endtask

    task automatic do_chk(input logic [3:0] b, input logic [3:0] o, input logic oreg,
                          input logic wb, input logic post);
        @(negedge clk);
        base_reg_i = b; offset_reg_i = o; offset_is_reg_i = oreg;
        writeback_i = wb; post_index_i = post;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset valid", 32'(ld_valid_o), 32'd0);
        check("R11 reset result", ld_result_o, 32'd0);
        rst_n = 1'b1;

        // Table walk over load vectors (R1 R2 R3 R4).
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ld_valid_i = 1'b1;
            ld_is_byte_i = LD_VEC[i][66];
            ld_offset_i = LD_VEC[i][65:64];
            ld_word_i = LD_VEC[i][63:32];
            @(negedge clk);
            ld_valid_i = 1'b0;
            check($sformatf("R1/R2/R3/R4 load vec %0d", i), ld_result_o, LD_VEC[i][31:0]);
            check("R5 valid pulse", 32'(ld_valid_o), 32'd1);
        end

        // R5: changed bus data without the strobe leaves the result alone.
        @(negedge clk);
        ld_word_i = 32'h5A5A5A5A; ld_offset_i = 2'd1; ld_is_byte_i = 1'b0;
        @(negedge clk);
        check("R5 no valid", 32'(ld_valid_o), 32'd0);
        check("R5 hold result", ld_result_o, 32'hB2C3D4A1);

        // Stores: R6 R7 R8 R9.
        do_store(32'h12345678, 1'b1, 2'd2, 1'b0, 32'h0);
        check("R6 byte replicate", st_bus_o, 32'h78787878);
        check("R9 lane off2", 32'(st_lane_en_o), 32'h2);
        do_store(32'h12345678, 1'b1, 2'd0, 1'b0, 32'h0);
        check("R9 lane off0", 32'(st_lane_en_o), 32'h8);
        do_store(32'h9ABCDEF0, 1'b1, 2'd3, 1'b0, 32'h0);
        check("R9 lane off3", 32'(st_lane_en_o), 32'h1);
        check("R6 byte replicate 2", st_bus_o, 32'hF0F0F0F0);
        do_store(32'h12345678, 1'b0, 2'd1, 1'b0, 32'h0);
        check("R7 word offset ignored", st_bus_o, 32'h12345678);
        check("R9 word lanes", 32'(st_lane_en_o), 32'hF);
        do_store(32'h80000001, 1'b0, 2'd3, 1'b0, 32'h0);
        check("R7 bit31 on bus31", st_bus_o, 32'h80000001);
        do_store(32'h11111111, 1'b0, 2'd0, 1'b1, 32'hFFFFFFF8);
        check("R8 pc wrap", st_bus_o, 32'h00000004);
        do_store(32'h11111111, 1'b1, 2'd1, 1'b1, 32'h00000100);
        check("R8 pc byte", st_bus_o, 32'h0C0C0C0C);

        // Illegal encodings: R10.
        do_chk(4'd15, 4'd2, 1'b0, 1'b1, 1'b0);
        check("R10 wb pc base", 32'(illegal_o), 32'd1);
        do_chk(4'd14, 4'd2, 1'b0, 1'b1, 1'b0);
        check("R10 wb non-pc base", 32'(illegal_o), 32'd0);
        do_chk(4'd1, 4'd15, 1'b1, 1'b0, 1'b0);
        check("R10 pc offset reg", 32'(illegal_o), 32'd1);
        do_chk(4'd1, 4'd15, 1'b0, 1'b0, 1'b0);
        check("R10 pc number imm offset", 32'(illegal_o), 32'd0);
        do_chk(4'd3, 4'd3, 1'b1, 1'b1, 1'b1);
        check("R10 post same reg", 32'(illegal_o), 32'd1);
        do_chk(4'd3, 4'd3, 1'b1, 1'b0, 1'b0);
        check("R10 pre same reg", 32'(illegal_o), 32'd0);

        // R11: reset mid-run clears the registered result.
        @(negedge clk);
        ld_valid_i = 1'b1; ld_is_byte_i = 1'b0; ld_offset_i = 2'd0; ld_word_i = 32'hCAFEF00D;
        @(negedge clk);
        ld_valid_i = 1'b0;
        check("R5 load before reset", ld_result_o, 32'hCAFEF00D);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset result", ld_result_o, 32'd0);
        check("R11 mid reset valid", 32'(ld_valid_o), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule